// File: doc/BRIEF.md
# Instruction Namespace Control Register Unit

This unit keeps, for every privilege level, a 32-bit namespace word that is silently appended to each fetched opcode before decode. The low bit chooses between two views. In the native view a binary page number selects one of several meanings for the 16-bit opcode space, and other fields carry an endianness flag and custom bits. In the foreign view a binary index names exactly one foreign architecture. Each level also has a saved-value register and a table of trap-default values, indexed by trap cause.

Software writes are accepted only when the implementation can hold the value. Any other value, including one with a reserved bit set, raises an illegal-instruction request in the same cycle and leaves the target unchanged. On trap entry or return the unit runs a fixed two-step swap. It then pulses a commit strobe that tells the core it may now redirect the PC. The word of the currently executing level goes to the decoder, and a one-cycle pulse marks every change of that word.

Top module: `opspace_csr`

## Requirements
- R1: After reset every namespace, saved-value and trap-default register reads zero. `ns_out` is zero, and `busy`, `pc_go`, `ns_changed` and `illegal_trap` are low.
- R2: A native word (bit 0 = 0) is holdable only under all of these conditions. The page in bits 5:1 is flagged in `PAGE_OK` (defaults: pages 0, 1 and 8). Bit 6, which selects big-endian, is set only if `BE_OK`. Bits 23:7 are zero. Bits 31:24 use only bits flagged in `CUST_OK` (default 8'h0F).
- R3: A foreign word (bit 0 = 1) is holdable only if the index in bits 7:1 is flagged in `ARCH_OK` (defaults: 0, 1, 16 and 64) and bits 31:8 are zero.
- R4: `illegal_trap` is asserted combinationally in the cycle of an accepted write whose value or target is not holdable. The target keeps its old value.
- R5: A holdable write takes effect at the clock edge of the write strobe and reads back from the next cycle on. `csr_sel` encoding: 0 = namespace, 1 = saved value, 2 = trap-default entry `csr_idx`.
- R6: Writes to the saved-value and trap-default registers are checked in the same way as namespace writes. `csr_sel` = 3 and `csr_lvl` >= `NPRIV` are always illegal and read as zero.
- R7: A trap-entry request accepted at edge E0 copies the namespace into the saved-value register at E0+1, then loads the namespace from the trap-default entry at E0+2. `pc_go` is high for the single cycle after E0+2.
- R8: A trap-return request runs the same steps in the other direction. The namespace is restored from the saved-value register at E0+1, then the saved-value register is reloaded from the trap-default entry at E0+2. `pc_go` follows as in R7.
- R9: The trap-default entry used by a swap is the one selected by `trap_cause` when `VECTORED` is set.
- R10: `busy` is high from E0 until `pc_go` has dropped. While `busy` is high, trap requests and software writes are ignored and never raise `illegal_trap`.
- R11: `ns_changed` is high for exactly one cycle whenever `ns_out` differs from its value in the previous cycle.
- R12: `ns_out` shows the namespace of level `cur_lvl` (zero for an absent level), and each level's registers are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_lvl | input | LW | Privilege level currently executing |
| csr_we | input | 1 | Software write strobe |
| csr_lvl | input | LW | Level addressed by software access |
| csr_sel | input | 2 | Register select: 0 namespace, 1 saved, 2 trap-default, 3 none |
| csr_idx | input | CW | Trap-default table entry for software access |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Combinational read data for the addressed register |
| illegal_trap | output | 1 | Illegal-instruction request for the current write |
| trap_enter | input | 1 | Trap-entry request |
| trap_return | input | 1 | Trap-return request |
| trap_lvl | input | LW | Level whose registers the swap uses |
| trap_cause | input | CW | Cause selecting the trap-default entry |
| busy | output | 1 | Swap sequence in progress |
| pc_go | output | 1 | One-cycle permission to update the PC |
| ns_out | output | 32 | Namespace word for the decoder |
| ns_changed | output | 1 | One-cycle pulse on any change of `ns_out` |

## Verification
The bench builds the unit with its defaults: three levels, a four-entry vectored trap-default table, pages 0, 1 and 8, architectures 0, 1, 16 and 64, big-endian allowed and four custom bits. With these values each legality branch can be hit by a single write: an absent page, a forbidden custom bit, a reserved bit, an absent architecture and stray foreign high bits. Four distinct table entries per level show which cause a swap read. Three levels make it possible to see that a swap or write on one level leaves the others untouched while `cur_lvl` moves between them.

// File: rtl/opspace_csr.sv
module opspace_csr #(
  parameter int NPRIV = 3,
  parameter int NVEC = 4,
  parameter bit VECTORED = 1'b1,
  parameter logic [31:0] PAGE_OK = 32'h0000_0103,
  parameter logic [127:0] ARCH_OK = 128'h0000_0000_0000_0001_0000_0000_0001_0003,
  parameter bit BE_OK = 1'b1,
  parameter logic [7:0] CUST_OK = 8'h0F,
  localparam int LW = (NPRIV > 1) ? $clog2(NPRIV) : 1,
  localparam int CW = (NVEC > 1) ? $clog2(NVEC) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] cur_lvl,
  input  logic          csr_we,
  input  logic [LW-1:0] csr_lvl,
  input  logic [1:0]    csr_sel,
  input  logic [CW-1:0] csr_idx,
  input  logic [31:0]   csr_wdata,
  output logic [31:0]   csr_rdata,
  output logic          illegal_trap,
  input  logic          trap_enter,
  input  logic          trap_return,
  input  logic [LW-1:0] trap_lvl,
  input  logic [CW-1:0] trap_cause,
  output logic          busy,
  output logic          pc_go,
  output logic [31:0]   ns_out,
  output logic          ns_changed
);

  typedef enum logic [1:0] {IDLE, STEP1, STEP2, GO} step_t;

  logic [31:0] act_q [NPRIV];
  logic [31:0] last_q [NPRIV];
  logic [31:0] tdef_q [NPRIV][NVEC];
  logic [31:0] ns_q;
  step_t       st;
  logic        ret_q;
  logic [LW-1:0] lvl_q;
  logic [CW-1:0] cause_q;

  function automatic logic holdable(input logic [31:0] v);
    if (!v[0])
      return PAGE_OK[v[5:1]] && (BE_OK || !v[6]) && (v[23:7] == '0) &&
             ((v[31:24] & ~CUST_OK) == '0);
    return ARCH_OK[v[7:1]] && (v[31:8] == '0);
  endfunction

  wire lvl_ok    = csr_lvl < NPRIV;
  wire target_ok = lvl_ok && (csr_sel != 2'd3);
  wire [CW-1:0] tix = VECTORED ? csr_idx : '0;
  wire [CW-1:0] cix = VECTORED ? cause_q : '0;
  wire wr_fire   = csr_we && !busy;
  wire req_ok    = !busy && (trap_enter || trap_return) && (trap_lvl < NPRIV);

  assign busy         = st != IDLE;
  assign pc_go        = st == GO;
  assign illegal_trap = wr_fire && !(target_ok && holdable(csr_wdata));
  assign ns_out       = (cur_lvl < NPRIV) ? act_q[cur_lvl] : '0;
  assign ns_changed   = ns_out != ns_q;

  always_comb begin
    csr_rdata = '0;
    if (lvl_ok)
      case (csr_sel)
        2'd0:    csr_rdata = act_q[csr_lvl];
        2'd1:    csr_rdata = last_q[csr_lvl];
        2'd2:    csr_rdata = tdef_q[csr_lvl][tix];
        default: csr_rdata = '0;
      endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < NPRIV; l++) begin
        act_q[l]  <= '0;
        last_q[l] <= '0;
        for (int e = 0; e < NVEC; e++) tdef_q[l][e] <= '0;
      end
      ns_q    <= '0;
      st      <= IDLE;
      ret_q   <= 1'b0;
      lvl_q   <= '0;
      cause_q <= '0;
    end else begin
      ns_q <= ns_out;
      if (wr_fire && !illegal_trap)
        case (csr_sel)
          2'd0:    act_q[csr_lvl] <= csr_wdata;
          2'd1:    last_q[csr_lvl] <= csr_wdata;
          default: tdef_q[csr_lvl][tix] <= csr_wdata;
        endcase
      case (st)
        IDLE: if (req_ok) begin
          st      <= STEP1;
          ret_q   <= !trap_enter;
          lvl_q   <= trap_lvl;
          cause_q <= trap_cause;
        end
        STEP1: begin
          if (ret_q) act_q[lvl_q] <= last_q[lvl_q];
          else       last_q[lvl_q] <= act_q[lvl_q];
          st <= STEP2;
        end
        STEP2: begin
          if (ret_q) last_q[lvl_q] <= tdef_q[lvl_q][cix];
          else       act_q[lvl_q] <= tdef_q[lvl_q][cix];
          st <= GO;
        end
        default: st <= IDLE;
      endcase
    end
  end

endmodule

// File: rtl/opspace_csr_chk.sv
module opspace_csr_chk #(
  parameter int LW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          csr_we,
  input logic [LW-1:0] csr_lvl,
  input logic [1:0]    csr_sel,
  input logic          illegal_trap,
  input logic          trap_enter,
  input logic [LW-1:0] trap_lvl,
  input logic          busy,
  input logic          pc_go,
  input logic [31:0]   ns_out,
  input logic          ns_changed,
  input logic [31:0]   act0,
  input logic [31:0]   last0
);

  assert_trap_needs_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_trap |-> csr_we);

  assert_illegal_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && illegal_trap && csr_sel == 2'd0 && csr_lvl == '0) |=> act0 == $past(act0));

  assert_entry_saves_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_enter && !busy && trap_lvl == '0) |=> ##1 (last0 == $past(act0)));

  assert_go_after_steps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pc_go |-> ($past(busy) && $past(busy, 2)));

  assert_go_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pc_go |=> !pc_go);

  assert_quiet_when_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !illegal_trap);

  assert_change_flagged_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ns_out != $past(ns_out)) |-> ns_changed);

endmodule

bind opspace_csr opspace_csr_chk #(.LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_lvl(csr_lvl), .csr_sel(csr_sel),
  .illegal_trap(illegal_trap), .trap_enter(trap_enter), .trap_lvl(trap_lvl),
  .busy(busy), .pc_go(pc_go), .ns_out(ns_out), .ns_changed(ns_changed),
  .act0(act_q[0]), .last0(last_q[0])
);

// File: tb/sim_opspace_csr.sv
`timescale 1ns/1ps
module sim_opspace_csr;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cur_lvl = '0, csr_lvl = '0, csr_sel = '0, csr_idx = '0;
  logic [1:0] trap_lvl = '0, trap_cause = '0;
  logic csr_we = 1'b0, trap_enter = 1'b0, trap_return = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata, ns_out;
  logic illegal_trap, busy, pc_go, ns_changed;

  always #4 clk = ~clk;

  opspace_csr u0 (.*);

  int n_cmp = 0, n_bad = 0, cycles = 0;
  string phase = "R1";

  logic [31:0] m_act [3], m_last [3], m_tdef [3][4];
  logic [31:0] m_prev;
  int m_stage, m_lvl, m_cause;
  bit m_ret;

  function automatic bit m_legal(logic [31:0] v);
    int pg, ar;
    if (v[0] == 1'b0) begin
      pg = int'(v[5:1]);
      if (!(pg == 0 || pg == 1 || pg == 8)) return 0;
      if ((v & 32'h00FF_FF80) != 0) return 0;
      if ((v & 32'hF000_0000) != 0) return 0;
      return 1;
    end
    ar = int'(v[7:1]);
    if (!(ar == 0 || ar == 1 || ar == 16 || ar == 64)) return 0;
    return (v >> 8) == 0;
  endfunction

  function automatic bit e_ill();
    if (!csr_we || m_stage != 0) return 0;
    if (csr_lvl > 2 || csr_sel == 3) return 1;
    return !m_legal(csr_wdata);
  endfunction

  function automatic logic [31:0] e_rd();
    if (csr_lvl > 2) return 0;
    if (csr_sel == 0) return m_act[csr_lvl];
    if (csr_sel == 1) return m_last[csr_lvl];
    if (csr_sel == 2) return m_tdef[csr_lvl][csr_idx];
    return 0;
  endfunction

  function automatic logic [31:0] e_out();
    return (cur_lvl > 2) ? 32'h0 : m_act[cur_lvl];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < 3; l++) begin
        m_act[l] = 0; m_last[l] = 0;
        for (int e = 0; e < 4; e++) m_tdef[l][e] = 0;
      end
      m_prev = 0; m_stage = 0; m_ret = 0; m_lvl = 0; m_cause = 0;
    end else begin
      m_prev = e_out();
      if (csr_we && m_stage == 0 && !e_ill()) begin
        if (csr_sel == 0) m_act[csr_lvl] = csr_wdata;
        else if (csr_sel == 1) m_last[csr_lvl] = csr_wdata;
        else m_tdef[csr_lvl][csr_idx] = csr_wdata;
      end
      case (m_stage)
        0: if ((trap_enter || trap_return) && trap_lvl <= 2) begin
             m_stage = 1; m_ret = !trap_enter; m_lvl = trap_lvl; m_cause = trap_cause;
           end
        1: begin
             if (m_ret) m_act[m_lvl] = m_last[m_lvl];
             else m_last[m_lvl] = m_act[m_lvl];
             m_stage = 2;
           end
        2: begin
             if (m_ret) m_last[m_lvl] = m_tdef[m_lvl][m_cause];
             else m_act[m_lvl] = m_tdef[m_lvl][m_cause];
             m_stage = 3;
           end
        default: m_stage = 0;
      endcase
    end
  end

  task automatic cmp(string what, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h at %0t", phase, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #3;
    cycles++;
    cmp("ns_out", ns_out, e_out());
    cmp("csr_rdata", csr_rdata, e_rd());
    cmp("illegal_trap", 32'(illegal_trap), 32'(e_ill()));
    cmp("busy", 32'(busy), 32'(m_stage != 0));
    cmp("pc_go", 32'(pc_go), 32'(m_stage == 3));
    cmp("ns_changed", 32'(ns_changed), 32'(e_out() != m_prev));
    if (cycles > 20000) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic wr(int lvl, int sel, int idx, logic [31:0] d);
    @(negedge clk);
    csr_we = 1; csr_lvl = 2'(lvl); csr_sel = 2'(sel); csr_idx = 2'(idx); csr_wdata = d;
    @(negedge clk);
    csr_we = 0;
    @(negedge clk);
  endtask

  task automatic trap(bit ret, int lvl, int cause, int wait_n);
    @(negedge clk);
    trap_enter = !ret; trap_return = ret; trap_lvl = 2'(lvl); trap_cause = 2'(cause);
    @(negedge clk);
    trap_enter = 0; trap_return = 0;
    repeat (wait_n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int l = 0; l < 3; l++)
      for (int s = 0; s < 3; s++) begin
        @(negedge clk); csr_lvl = 2'(l); csr_sel = 2'(s);
      end

    phase = "R2";
    wr(0, 0, 0, 32'h0000_0002);
    wr(0, 0, 0, 32'h0000_0010);
    wr(0, 0, 0, 32'h0000_0004);
    wr(0, 0, 0, 32'h0000_0042);
    wr(0, 0, 0, 32'h0000_8000);
    wr(0, 0, 0, 32'h0000_0080);
    wr(0, 0, 0, 32'h0300_0000);
    wr(0, 0, 0, 32'h1000_0000);
    phase = "R3";
    wr(0, 0, 0, 32'h0000_0001);
    wr(0, 0, 0, 32'h0000_0021);
    wr(0, 0, 0, 32'h0000_0081);
    wr(0, 0, 0, 32'h0000_0005);
    wr(0, 0, 0, 32'h0000_0101);
    phase = "R4";
    wr(0, 0, 0, 32'h0000_0006);
    phase = "R5";
    wr(0, 0, 0, 32'h0000_0040);
    phase = "R6";
    wr(0, 1, 0, 32'h0000_0003);
    wr(0, 1, 0, 32'h0000_0200);
    wr(0, 2, 1, 32'h0000_0023);
    wr(0, 2, 1, 32'h0000_0012);
    wr(0, 3, 0, 32'h0000_0002);
    wr(3, 0, 0, 32'h0000_0002);
    phase = "R9";
    wr(1, 2, 0, 32'h0000_0002);
    wr(1, 2, 1, 32'h0000_0010);
    wr(1, 2, 2, 32'h0000_0021);
    wr(1, 2, 3, 32'h0000_0081);
    wr(1, 0, 0, 32'h0000_0040);
    phase = "R7";
    cur_lvl = 1; csr_lvl = 1; csr_sel = 1;
    trap(0, 1, 2, 5);
    phase = "R8";
    trap(1, 1, 3, 5);
    phase = "R9";
    trap(0, 1, 1, 5);
    trap(1, 1, 0, 5);
    phase = "R10";
    trap(0, 0, 1, 0);
    csr_we = 1; csr_lvl = 0; csr_sel = 0; csr_wdata = 32'h0000_0004;
    @(negedge clk);
    csr_wdata = 32'h0000_0002;
    trap_return = 1; trap_lvl = 0;
    @(negedge clk);
    csr_we = 0; trap_return = 0;
    repeat (4) @(negedge clk);
    phase = "R12";
    for (int l = 0; l < 4; l++) begin
      @(negedge clk); cur_lvl = 2'(l);
      @(negedge clk);
    end
    phase = "R11";
    cur_lvl = 0;
    wr(0, 0, 0, 32'h0000_0021);
    wr(0, 0, 0, 32'h0000_0021);
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule